// File: doc/BRIEF.md
# Byte Lane Load/Store Aligner

This block connects a core's load/store pipeline to a data memory that is one 32-bit word wide. On the request side it forms the effective byte address from a base value plus a signed 12-bit offset. It then produces the word-aligned memory address, a 4-bit per-byte write strobe and write data whose bytes sit on the correct lanes. Lane 0 always holds the byte at the lowest address, so byte ordering is little-endian. A misaligned halfword or word access raises a flag, and that access drives no strobes.

On the response side the block takes the 32-bit word that memory returns, together with the access size, a signedness select and the two low address bits. From these it selects the addressed byte, halfword or word and extends it to a 32-bit register value, using sign extension or zero extension as selected.

Both paths are purely combinational. The core registers the results wherever its pipeline needs them.

Top module: `byte_lane_unit`

## Requirements
- R1: `mem_addr` equals (`req_base` + sign-extended `req_off`) with bits [1:0] forced to zero.
- R2: `req_misalign` is 1 for a halfword access (size code 1) whose effective address has bit 0 set, and for a word access (size 2 or 3) whose effective address has bits [1:0] not equal to 0. A byte access (size 0) never sets it.
- R3: When `req_store` is 1 and the access is aligned, `mem_wstrb` is as follows, where `ea` is the effective address:
  - byte: `1 << ea[1:0]`
  - halfword: `4'b0011 << (2*ea[1])`
  - word: `4'b1111`
  
  When `req_store` is 0, or the access is misaligned, `mem_wstrb` is 0.
- R4: For a byte store, `mem_wdata` carries `req_wdata[7:0]` on all four lanes. For a halfword store it carries `req_wdata[15:0]` on both halves. For a word store it equals `req_wdata`. Register bits above the access size have no effect on the strobed lanes.
- R5: A signed byte load (`ld_size`=0, `ld_unsigned`=0) returns the byte at lane `ld_lo`, sign-extended from bit 7.
- R6: An unsigned byte load returns that byte with bits [31:8] equal to zero.
- R7: A halfword load returns the halfword at lanes {`ld_lo[1]`,0} and {`ld_lo[1]`,1}, sign-extended from bit 15 or zero-extended as `ld_unsigned` selects. `ld_lo[0]` is ignored.
- R8: A word load (size 2) returns `ld_word` unchanged, whatever the values of `ld_unsigned` and `ld_lo`.
- R9: Size code 3 behaves exactly like a word access, on both paths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| req_base | input | ADDR_W | Base address from the register file |
| req_off | input | OFF_W | Signed byte offset |
| req_size | input | 2 | Access size: 0 byte, 1 halfword, 2 or 3 word |
| req_store | input | 1 | Request is a store |
| req_wdata | input | 32 | Register value to store |
| ld_word | input | 32 | Word returned by memory |
| ld_size | input | 2 | Size of the load being completed |
| ld_unsigned | input | 1 | 1 for zero extension, 0 for sign extension |
| ld_lo | input | 2 | Effective address bits [1:0] of the load |
| mem_addr | output | ADDR_W | Word-aligned memory address |
| mem_wstrb | output | 4 | Per-byte write enable, bit n drives lane n |
| mem_wdata | output | 32 | Lane-positioned store data |
| req_misalign | output | 1 | Access alignment violated |
| ld_data | output | 32 | Extended load result |

## Verification
The assertions assume that every input is settled to a known value whenever they are evaluated. In particular, they assume the load-side fields describe one consistent response, with the same size and low bits that the matching request used. The stimulus drives all inputs together, away from the clock edge, from bounded random values. Every size code, including the reserved code 3, is drawn, and so is every offset sign and both store/no-store cases. As a result, misaligned, aligned and idle requests all occur without any input being left undriven.

// File: rtl/lane_unit_pkg.sv
package lane_unit_pkg;
    localparam int LANES  = 4;
    localparam int BYTE_W = 8;
    localparam int WORD_W = LANES * BYTE_W;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_WIDE = 2'b11
    } acc_size_e;
endpackage

// File: rtl/lane_addr_gen.sv
module lane_addr_gen
    import lane_unit_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 12
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [OFF_W-1:0]  off_i,
    input  acc_size_e         size_i,
    output logic [1:0]        lo_o,
    output logic [ADDR_W-1:0] word_addr_o,
    output logic              misalign_o
);
    localparam int EXT_W = ADDR_W - OFF_W;

    logic [ADDR_W-1:0] eff;

    always_comb begin
        eff         = base_i + {{EXT_W{off_i[OFF_W-1]}}, off_i};
        lo_o        = eff[1:0];
        word_addr_o = {eff[ADDR_W-1:2], 2'b00};
        unique case (size_i)
            SZ_BYTE: misalign_o = 1'b0;
            SZ_HALF: misalign_o = eff[0];
            default: misalign_o = |eff[1:0];
        endcase
    end
endmodule

// File: rtl/lane_store_pack.sv
module lane_store_pack
    import lane_unit_pkg::*;
(
    input  acc_size_e          size_i,
    input  logic [1:0]         lo_i,
    input  logic               store_i,
    input  logic               misalign_i,
    input  logic [WORD_W-1:0]  reg_i,
    output logic [LANES-1:0]   strobe_o,
    output logic [WORD_W-1:0]  wdata_o
);
    logic [LANES-1:0] mask;
    logic [1:0]       shamt;

    always_comb begin
        unique case (size_i)
            SZ_BYTE: begin mask = 4'b0001; shamt = lo_i;           end
            SZ_HALF: begin mask = 4'b0011; shamt = {lo_i[1], 1'b0}; end
            default: begin mask = 4'b1111; shamt = 2'b00;          end
        endcase
        strobe_o = (store_i && !misalign_i) ? (mask << shamt) : '0;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_comb begin
            unique case (size_i)
                SZ_BYTE: wdata_o[g*BYTE_W +: BYTE_W] = reg_i[0 +: BYTE_W];
                SZ_HALF: wdata_o[g*BYTE_W +: BYTE_W] = reg_i[(g%2)*BYTE_W +: BYTE_W];
                default: wdata_o[g*BYTE_W +: BYTE_W] = reg_i[g*BYTE_W +: BYTE_W];
            endcase
        end
    end
endmodule

// File: rtl/lane_load_extract.sv
module lane_load_extract
    import lane_unit_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    input  acc_size_e         size_i,
    input  logic              unsigned_i,
    input  logic [1:0]        lo_i,
    output logic [WORD_W-1:0] data_o
);
    logic [WORD_W-1:0] sh_b;
    logic [WORD_W-1:0] sh_h;
    logic [7:0]        b;
    logic [15:0]       h;

    always_comb begin
        sh_b = word_i >> {lo_i, 3'b000};
        sh_h = word_i >> {lo_i[1], 4'b0000};
        b    = sh_b[7:0];
        h    = sh_h[15:0];
        unique case (size_i)
            SZ_BYTE: data_o = {{(WORD_W-8){~unsigned_i & b[7]}}, b};
            SZ_HALF: data_o = {{(WORD_W-16){~unsigned_i & h[15]}}, h};
            default: data_o = word_i;
        endcase
    end
endmodule

// File: rtl/byte_lane_unit.sv
module byte_lane_unit
    import lane_unit_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 12
) (
    input  logic [ADDR_W-1:0] req_base,
    input  logic [OFF_W-1:0]  req_off,
    input  logic [1:0]        req_size,
    input  logic              req_store,
    input  logic [31:0]       req_wdata,
    input  logic [31:0]       ld_word,
    input  logic [1:0]        ld_size,
    input  logic              ld_unsigned,
    input  logic [1:0]        ld_lo,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [3:0]        mem_wstrb,
    output logic [31:0]       mem_wdata,
    output logic              req_misalign,
    output logic [31:0]       ld_data
);
    acc_size_e  st_sz;
    acc_size_e  rd_sz;
    logic [1:0] st_lo;

    assign st_sz = acc_size_e'(req_size);
    assign rd_sz = acc_size_e'(ld_size);

    lane_addr_gen #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) i_addr (
        .base_i      (req_base),
        .off_i       (req_off),
        .size_i      (st_sz),
        .lo_o        (st_lo),
        .word_addr_o (mem_addr),
        .misalign_o  (req_misalign)
    );

    lane_store_pack i_pack (
        .size_i     (st_sz),
        .lo_i       (st_lo),
        .store_i    (req_store),
        .misalign_i (req_misalign),
        .reg_i      (req_wdata),
        .strobe_o   (mem_wstrb),
        .wdata_o    (mem_wdata)
    );

    lane_load_extract i_extract (
        .word_i     (ld_word),
        .size_i     (rd_sz),
        .unsigned_i (ld_unsigned),
        .lo_i       (ld_lo),
        .data_o     (ld_data)
    );

    // Cross-module checks on settled combinational values
    always_comb begin
        assert_word_aligned_R1: assert (mem_addr[1:0] == 2'b00);
        if (req_misalign) begin
            assert_no_strobe_misaligned_R3: assert (mem_wstrb == 4'b0000);
        end
        if (mem_wstrb != 4'b0000) begin
            assert_strobe_width_R3: assert ($countones(mem_wstrb) ==
                ((req_size == 2'd0) ? 1 : (req_size == 2'd1) ? 2 : 4));
        end
        if (req_size == 2'd0) begin
            for (int k = 0; k < LANES; k++) begin
                if (mem_wstrb[k]) begin
                    assert_byte_lane_R4: assert (mem_wdata[k*8 +: 8] == req_wdata[7:0]);
                end
            end
        end
        if (ld_size == 2'd0 && !ld_unsigned) begin
            assert_sext_byte_R5: assert (ld_data[31:8] == {24{ld_data[7]}});
        end
        if (ld_size == 2'd0 && ld_unsigned) begin
            assert_zext_byte_R6: assert (ld_data[31:8] == 24'd0);
        end
    end
endmodule

// File: tb/test_byte_lane_unit.sv
module test_byte_lane_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] req_base = '0;
    logic [11:0] req_off = '0;
    logic [1:0]  req_size = '0;
    logic        req_store = 1'b0;
    logic [31:0] req_wdata = '0;
    logic [31:0] ld_word = '0;
    logic [1:0]  ld_size = '0;
    logic        ld_unsigned = 1'b0;
    logic [1:0]  ld_lo = '0;
    logic [31:0] mem_addr;
    logic [3:0]  mem_wstrb;
    logic [31:0] mem_wdata;
    logic        req_misalign;
    logic [31:0] ld_data;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    byte_lane_unit i_byte_lane_unit (.*);

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] f_ea(logic [31:0] b, logic [11:0] o);
        return b + {{20{o[11]}}, o};
    endfunction

    function automatic logic f_mis(logic [1:0] sz, logic [31:0] ea);
        if (sz == 2'd0) return 1'b0;
        if (sz == 2'd1) return ea[0];
        return ea[1:0] != 2'b00;
    endfunction

    function automatic logic [3:0] f_strb(logic [1:0] sz, logic st, logic [31:0] ea);
        if (!st || f_mis(sz, ea)) return 4'b0000;
        if (sz == 2'd0) return 4'b0001 << ea[1:0];
        if (sz == 2'd1) return ea[1] ? 4'b1100 : 4'b0011;
        return 4'b1111;
    endfunction

    function automatic logic [31:0] f_wd(logic [1:0] sz, logic [31:0] r);
        if (sz == 2'd0) return {4{r[7:0]}};
        if (sz == 2'd1) return {2{r[15:0]}};
        return r;
    endfunction

    function automatic logic [31:0] f_ld(logic [31:0] w, logic [1:0] sz, logic u, logic [1:0] lo);
        logic [7:0]  b;
        logic [15:0] h;
        b = w[lo*8 +: 8];
        h = lo[1] ? w[31:16] : w[15:0];
        if (sz == 2'd0) return u ? {24'd0, b} : {{24{b[7]}}, b};
        if (sz == 2'd1) return u ? {16'd0, h} : {{16{h[15]}}, h};
        return w;
    endfunction

    function automatic logic [31:0] f_merge(logic [31:0] old, logic [3:0] s, logic [31:0] d);
        logic [31:0] r;
        r = old;
        for (int k = 0; k < 4; k++) if (s[k]) r[k*8 +: 8] = d[k*8 +: 8];
        return r;
    endfunction

    task automatic drive_st(logic [31:0] b, logic [11:0] o, logic [1:0] sz, logic st, logic [31:0] d);
        @(negedge clk);
        req_base = b; req_off = o; req_size = sz; req_store = st; req_wdata = d;
        #1;
    endtask

    task automatic drive_ld(logic [31:0] w, logic [1:0] sz, logic u, logic [1:0] lo);
        @(negedge clk);
        ld_word = w; ld_size = sz; ld_unsigned = u; ld_lo = lo;
        #1;
    endtask

    task automatic check_st(string tag);
        logic [31:0] ea;
        logic [3:0]  es;
        ea = f_ea(req_base, req_off);
        es = f_strb(req_size, req_store, ea);
        chk({tag, " R1 addr"}, mem_addr, {ea[31:2], 2'b00});
        chk({tag, " R2 misalign"}, {31'd0, req_misalign}, {31'd0, f_mis(req_size, ea)});
        chk({tag, " R3 strobe"}, {28'd0, mem_wstrb}, {28'd0, es});
        chk({tag, " R4 wdata"}, f_merge(32'h0, es, mem_wdata), f_merge(32'h0, es, f_wd(req_size, req_wdata)));
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        #1;
        chk("reset R3 strobe idle", {28'd0, mem_wstrb}, 32'd0);
        chk("reset R1 addr idle", mem_addr, 32'd0);
        rst = 1'b0;

        // Directed: example from the little-endian description
        drive_ld(32'h0000_0180, 2'd0, 1'b0, 2'd1);
        chk("R5 byte lane1 signed", ld_data, 32'h0000_0001);
        drive_ld(32'h0000_0180, 2'd0, 1'b0, 2'd0);
        chk("R5 byte lane0 signed", ld_data, 32'hFFFF_FF80);
        drive_ld(32'h0000_0180, 2'd0, 1'b1, 2'd0);
        chk("R6 byte lane0 unsigned", ld_data, 32'h0000_0080);
        drive_st(32'h100, 12'd2, 2'd0, 1'b1, 32'hFFFF_FF80);
        chk("R3 byte store lane2", {28'd0, mem_wstrb}, 32'h4);
        chk("R4 byte store merge", f_merge(32'h0000_0180, mem_wstrb, mem_wdata), 32'h0080_0180);
        // Negative offset word store
        drive_st(32'h104, 12'hFFC, 2'd2, 1'b1, 32'hDEAD_BEEF);
        chk("R1 negative offset", mem_addr, 32'h100);
        chk("R3 word strobe", {28'd0, mem_wstrb}, 32'hF);
        // Misaligned halfword and word
        drive_st(32'h201, 12'd0, 2'd1, 1'b1, 32'h1234);
        chk("R2 half odd misalign", {31'd0, req_misalign}, 32'd1);
        chk("R3 misaligned no strobe", {28'd0, mem_wstrb}, 32'd0);
        drive_st(32'h202, 12'd0, 2'd3, 1'b1, 32'h1234);
        chk("R9 wide code misalign", {31'd0, req_misalign}, 32'd1);
        // Upper half store
        drive_st(32'h302, 12'd0, 2'd1, 1'b1, 32'hAAAA_5A3C);
        chk("R3 half upper strobe", {28'd0, mem_wstrb}, 32'hC);
        chk("R4 half upper data", mem_wdata[31:16], 32'h5A3C);
        // Halfword and word loads
        drive_ld(32'h8001_7FFE, 2'd1, 1'b0, 2'd3);
        chk("R7 half upper signed lo0 ignored", ld_data, 32'hFFFF_8001);
        drive_ld(32'h8001_7FFE, 2'd1, 1'b1, 2'd0);
        chk("R7 half lower unsigned", ld_data, 32'h0000_7FFE);
        drive_ld(32'h8765_4321, 2'd2, 1'b1, 2'd3);
        chk("R8 word passthrough", ld_data, 32'h8765_4321);
        drive_ld(32'h8765_4321, 2'd3, 1'b0, 2'd1);
        chk("R9 wide code load", ld_data, 32'h8765_4321);

        for (int i = 0; i < 400; i++) begin
            drive_st($urandom, 12'($urandom), 2'($urandom), ($urandom % 4) != 0, $urandom);
            check_st("rand");
        end
        for (int i = 0; i < 400; i++) begin
            drive_ld($urandom, 2'($urandom), 1'($urandom), 2'($urandom));
            chk("rand R5 R6 R7 R8 R9 load", ld_data, f_ld(ld_word, ld_size, ld_unsigned, ld_lo));
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule